// File: doc/BRIEF.md
# Serial Command Decoder

This block sits between a byte-wide UART receiver and a UART transmitter on a 9600-baud control link. It gathers received bytes into lines that end in a newline, reads the first character as a one-letter command, and reads any further characters as an unsigned decimal argument. Each command either updates a setting held in the block or reads a value back. Every line gets exactly one reply, which is sent byte by byte to the transmitter.

Seven uppercase letters are recognised. P reads or writes the 16-bit pulses-per-minute calibration value. T reads the current time, or loads a new time given as a four-digit HHMM number. M reads the running mode, which is supplied by the clock core. E, A, C and R read or write the single-bit echo, auto-send, alternate-character-set and run settings. A reply is an optional decimal value followed by `=OK`, or it is `=ERR` followed by `:UC` for a letter the block does not know or `:INV` for an argument it rejects. Every reply ends in a newline.

The receiver is seen as a byte plus a one-cycle valid strobe. The transmitter is seen as a byte plus valid, with a ready input from the transmitter. While a reply is pending, the block takes no new input.

Top module: `serial_cmd_decoder`

## Requirements
- R1: After reset, the pulses-per-minute value is 26400, echo, auto-send and alternate character set are 0, run is 1, and tx_valid is low.
- R2: A P line whose argument is 1 to 65535 stores that value and is answered `=OK` followed by a newline (0x0A).
- R3: A P argument of 0, or one above 65535, is answered `=ERR:INV` plus a newline, and the stored value does not change.
- R4: A bare P returns the stored value, and a bare M returns mode_code, in decimal ASCII digits with no leading zeros, followed by `=OK` and a newline. M with an argument gets `=ERR:INV`.
- R5: E, A, C and R accept only the arguments 0 and 1 and store them. Any other value gets `:INV`. A bare letter returns the stored bit as the digit 0 or 1 before `=OK`.
- R6: T with an argument HHMM, where HH is below 24 and MM is below 60, pulses time_load for one cycle with load_hours=HH and load_minutes=MM. Any other T argument gets `:INV` and no pulse. A bare T returns cur_hours*100+cur_minutes in decimal.
- R7: A line whose first character is not one of the seven uppercase letters, including a lowercase letter or an empty line, is answered `=ERR:UC` plus a newline.
- R8: A line of more than 8 characters, not counting carriage returns and the newline, is answered `:INV` and changes nothing. A line of exactly 8 characters is processed normally. A carriage return (0x0D) anywhere in a line is ignored.
- R9: A character in the argument that is not a digit '0'..'9' makes the line `:INV`.
- R10: Bytes received between the newline that ends a line and the transmitter's acceptance of the last byte of its reply are discarded.
- R11: tx_valid rises on the third clock edge, counting the edge that takes in the newline. tx_data stays stable while tx_valid is high and tx_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | One-cycle strobe: rx_data holds a received byte |
| rx_data | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter can take a byte |
| tx_valid | output | 1 | tx_data holds a reply byte |
| tx_data | output | 8 | Reply byte |
| cur_hours | input | 5 | Current hours, read by a bare T |
| cur_minutes | input | 6 | Current minutes, read by a bare T |
| mode_code | input | 3 | Current mode number, read by M |
| ppm_value | output | 16 | Pulses-per-minute calibration value |
| echo_en | output | 1 | Echo setting (E) |
| auto_send_en | output | 1 | Auto-send setting (A) |
| charset_alt | output | 1 | Alternate character set (C) |
| run_en | output | 1 | Run state (R) |
| time_load | output | 1 | One-cycle strobe that loads a new time |
| load_hours | output | 5 | Hours to load |
| load_minutes | output | 6 | Minutes to load |

## Verification
The edge that takes in a newline starts a fixed pipeline. The settings and the time_load strobe change on the next edge, and the first reply byte becomes valid on the edge after that. The bench measures this latency once, counting edges from the newline to the rise of tx_valid, and expects exactly two more edges. A monitor pops expected reply bytes from a scoreboard queue at every falling edge on which tx_valid and tx_ready are both high, so the reply stream is checked byte by byte whatever the back-pressure. The settings are read only after a reply has fully drained, well after they are due, and time_load pulses are counted on the falling edges.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;

  localparam int ARG_W      = 16;
  localparam int DEC_DIGITS = 5;
  localparam int BCD_W      = 4 * DEC_DIGITS;
  localparam int ACC_W      = ARG_W + 4;
  localparam int MSG_MAX    = DEC_DIGITS + 9;
  localparam int IDX_W      = $clog2(MSG_MAX);

  localparam logic [7:0] CH_LF = 8'h0A;
  localparam logic [7:0] CH_CR = 8'h0D;

  typedef enum logic [1:0] {RS_OK, RS_UC, RS_INV} rsp_code_e;

  typedef struct packed {
    logic [7:0]       letter;
    logic             has_letter;
    logic             has_arg;
    logic [ARG_W-1:0] arg;
    logic             arg_bad;
    logic             too_long;
  } line_t;

  function automatic logic is_digit(input logic [7:0] b);
    return (b >= 8'h30) && (b <= 8'h39);
  endfunction

  // value*10 + digit, wide enough to show overflow past ARG_W bits
  function automatic logic [ACC_W-1:0] acc_dec(input logic [ARG_W-1:0] v,
                                               input logic [7:0] b);
    logic [ACC_W-1:0] d;
    d = ACC_W'(b - 8'h30);
    return (ACC_W'(v) * ACC_W'(10)) + d;
  endfunction

  // shift-and-add-3 binary to packed BCD
  function automatic logic [BCD_W-1:0] to_bcd(input logic [ARG_W-1:0] v);
    logic [BCD_W+ARG_W-1:0] s;
    s = {{BCD_W{1'b0}}, v};
    for (int i = 0; i < ARG_W; i++) begin
      for (int d = 0; d < DEC_DIGITS; d++) begin
        if (s[ARG_W+4*d +: 4] >= 4'd5) s[ARG_W+4*d +: 4] = s[ARG_W+4*d +: 4] + 4'd3;
      end
      s = s << 1;
    end
    return s[BCD_W+ARG_W-1:ARG_W];
  endfunction

  // number of significant decimal digits, at least one
  function automatic logic [2:0] dec_len(input logic [BCD_W-1:0] bcd);
    logic [2:0] n;
    n = 3'd1;
    for (int d = 1; d < DEC_DIGITS; d++) begin
      if (bcd[4*d +: 4] != 4'd0) n = 3'(d + 1);
    end
    return n;
  endfunction

  function automatic logic hhmm_ok(input logic [ARG_W-1:0] v);
    return ((v / ARG_W'(100)) < ARG_W'(24)) && ((v % ARG_W'(100)) < ARG_W'(60));
  endfunction

  function automatic logic [ARG_W-1:0] hhmm_hi(input logic [ARG_W-1:0] v);
    return v / ARG_W'(100);
  endfunction

  function automatic logic [ARG_W-1:0] hhmm_lo(input logic [ARG_W-1:0] v);
    return v % ARG_W'(100);
  endfunction

  function automatic logic [ARG_W-1:0] hhmm_join(input logic [ARG_W-1:0] h,
                                                 input logic [ARG_W-1:0] m);
    return h * ARG_W'(100) + m;
  endfunction

  function automatic logic [IDX_W-1:0] suffix_len(input rsp_code_e c);
    case (c)
      RS_OK:   return IDX_W'(4);
      RS_UC:   return IDX_W'(8);
      default: return IDX_W'(9);
    endcase
  endfunction

  // status text: "=OK\n", "=ERR:UC\n", "=ERR:INV\n"
  function automatic logic [7:0] suffix_char(input rsp_code_e c,
                                             input logic [IDX_W-1:0] j);
    logic [7:0] ch;
    ch = CH_LF;
    if (j == IDX_W'(0)) ch = "=";
    else if (c == RS_OK) begin
      if (j == IDX_W'(1)) ch = "O";
      else if (j == IDX_W'(2)) ch = "K";
    end else begin
      case (j)
        IDX_W'(1): ch = "E";
        IDX_W'(2): ch = "R";
        IDX_W'(3): ch = "R";
        IDX_W'(4): ch = ":";
        IDX_W'(5): ch = (c == RS_UC) ? "U" : "I";
        IDX_W'(6): ch = (c == RS_UC) ? "C" : "N";
        IDX_W'(7): ch = (c == RS_UC) ? CH_LF : "V";
        default:   ch = CH_LF;
      endcase
    end
    return ch;
  endfunction

endpackage

// File: rtl/cmd_line_asm.sv
module cmd_line_asm
  import cmd_dec_pkg::*;
#(
  parameter int MAX_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       reply_done,
  output line_t      line_o,
  output logic       line_done,
  output logic       busy
);

  localparam int CNT_W = $clog2(MAX_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_LEN);

  logic [CNT_W-1:0] cnt;
  logic [7:0]       letter;
  logic             has_letter, has_arg, arg_bad, too_long, hold;
  logic [ARG_W-1:0] arg;
  logic [ACC_W-1:0] acc_next;
  logic             accept;

  assign accept   = rx_valid && !hold;
  assign acc_next = acc_dec(arg, rx_data);
  assign busy     = hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; letter <= '0; has_letter <= 1'b0; has_arg <= 1'b0;
      arg <= '0; arg_bad <= 1'b0; too_long <= 1'b0; hold <= 1'b0;
      line_done <= 1'b0; line_o <= '0;
    end else begin
      line_done <= 1'b0;
      if (reply_done) hold <= 1'b0;
      if (accept) begin
        if (rx_data == CH_LF) begin
          line_o    <= '{letter: letter, has_letter: has_letter, has_arg: has_arg,
                         arg: arg, arg_bad: arg_bad, too_long: too_long};
          line_done <= 1'b1;
          hold      <= 1'b1;
          cnt <= '0; letter <= '0; has_letter <= 1'b0; has_arg <= 1'b0;
          arg <= '0; arg_bad <= 1'b0; too_long <= 1'b0;
        end else if (rx_data == CH_CR) begin
          // carriage return carries no meaning
        end else if (cnt == CNT_MAX) begin
          too_long <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
          if (cnt == '0) begin
            letter     <= rx_data;
            has_letter <= 1'b1;
          end else begin
            has_arg <= 1'b1;
            if (!is_digit(rx_data)) arg_bad <= 1'b1;
            else if (!arg_bad) begin
              if (acc_next > ACC_W'({ARG_W{1'b1}})) arg_bad <= 1'b1;
              else arg <= acc_next[ARG_W-1:0];
            end
          end
        end
      end
    end
  end

  // R10: a line completes as a single pulse, never twice in a row
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);

  // R10: bytes offered while a line waits for its reply do not complete a line
  p_hold_ignores_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && rx_valid) |=> !line_done);

  // R8: the character count never passes the line limit
  p_len_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_MAX);

endmodule

// File: rtl/cmd_exec.sv
module cmd_exec
  import cmd_dec_pkg::*;
#(
  parameter int               HOUR_W     = 5,
  parameter int               MIN_W      = 6,
  parameter int               MODE_W     = 3,
  parameter logic [ARG_W-1:0] PPM_RESET  = 16'd26400,
  parameter logic [3:0]       FLAG_RESET = 4'b1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  line_t             line_i,
  input  logic              line_done,
  input  logic [HOUR_W-1:0] cur_hours,
  input  logic [MIN_W-1:0]  cur_minutes,
  input  logic [MODE_W-1:0] mode_code,
  output logic [ARG_W-1:0]  ppm_value,
  output logic [3:0]        flags,
  output logic              time_load,
  output logic [HOUR_W-1:0] load_hours,
  output logic [MIN_W-1:0]  load_minutes,
  output logic              rsp_valid,
  output rsp_code_e         rsp_code,
  output logic              rsp_show,
  output logic [ARG_W-1:0]  rsp_num
);

  localparam int NFLAG = 4;

  rsp_code_e        st;
  logic             show, wr_ppm, wr_flag, wr_time;
  logic [ARG_W-1:0] num;
  logic [1:0]       fsel;

  always_comb begin
    st = RS_OK; show = 1'b0; num = '0;
    wr_ppm = 1'b0; wr_flag = 1'b0; wr_time = 1'b0; fsel = 2'd0;
    if (line_i.too_long) st = RS_INV;
    else if (!line_i.has_letter) st = RS_UC;
    else begin
      case (line_i.letter)
        "P": begin
          if (!line_i.has_arg) begin show = 1'b1; num = ppm_value; end
          else if (line_i.arg_bad || line_i.arg == '0) st = RS_INV;
          else wr_ppm = 1'b1;
        end
        "E", "A", "C", "R": begin
          case (line_i.letter)
            "E":     fsel = 2'd0;
            "A":     fsel = 2'd1;
            "C":     fsel = 2'd2;
            default: fsel = 2'd3;
          endcase
          if (!line_i.has_arg) begin show = 1'b1; num = ARG_W'(flags[fsel]); end
          else if (line_i.arg_bad || line_i.arg > ARG_W'(1)) st = RS_INV;
          else wr_flag = 1'b1;
        end
        "T": begin
          if (!line_i.has_arg) begin
            show = 1'b1;
            num  = hhmm_join(ARG_W'(cur_hours), ARG_W'(cur_minutes));
          end else if (line_i.arg_bad || !hhmm_ok(line_i.arg)) st = RS_INV;
          else wr_time = 1'b1;
        end
        "M": begin
          if (!line_i.has_arg) begin show = 1'b1; num = ARG_W'(mode_code); end
          else st = RS_INV;
        end
        default: st = RS_UC;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ppm_value <= PPM_RESET; time_load <= 1'b0;
      load_hours <= '0; load_minutes <= '0;
      rsp_valid <= 1'b0; rsp_code <= RS_OK; rsp_show <= 1'b0; rsp_num <= '0;
    end else begin
      rsp_valid <= line_done;
      time_load <= line_done && wr_time;
      if (line_done) begin
        rsp_code <= st; rsp_show <= show; rsp_num <= num;
        if (wr_ppm) ppm_value <= line_i.arg;
        if (wr_time) begin
          load_hours   <= HOUR_W'(hhmm_hi(line_i.arg));
          load_minutes <= MIN_W'(hhmm_lo(line_i.arg));
        end
      end
    end
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) flags[g] <= FLAG_RESET[g];
      else if (line_done && wr_flag && fsel == 2'(g)) flags[g] <= line_i.arg[0];
    end
  end

  // R3: the calibration value can never be zero
  p_ppm_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ppm_value != '0);

  // R2: the calibration value moves only right after a completed line
  p_ppm_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ppm_value) |-> $past(line_done));

  // R6: a time load always carries a legal hour and minute
  p_time_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    time_load |-> (load_hours < HOUR_W'(24) && load_minutes < MIN_W'(60)));

  // R6: a time load pulse lasts one cycle
  p_time_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    time_load |=> !time_load);

endmodule

// File: rtl/cmd_reply_tx.sv
module cmd_reply_tx
  import cmd_dec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rsp_valid,
  input  rsp_code_e        rsp_code,
  input  logic             rsp_show,
  input  logic [ARG_W-1:0] rsp_num,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic [7:0]       tx_data,
  output logic             reply_done
);

  logic             active, show_q;
  rsp_code_e        code_q;
  logic [BCD_W-1:0] bcd_q;
  logic [2:0]       ndig_q;
  logic [IDX_W-1:0] idx, pre, last_idx;
  logic [BCD_W-1:0] shifted;

  assign pre        = show_q ? IDX_W'(ndig_q) : '0;
  assign last_idx   = pre + suffix_len(code_q) - 1'b1;
  assign tx_valid   = active;
  assign reply_done = active && tx_ready && (idx == last_idx);
  assign shifted    = bcd_q >> (4 * (int'(ndig_q) - 1 - int'(idx)));

  always_comb begin
    if (idx < pre) tx_data = 8'h30 + {4'd0, shifted[3:0]};
    else           tx_data = suffix_char(code_q, idx - pre);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; show_q <= 1'b0; code_q <= RS_OK;
      bcd_q <= '0; ndig_q <= 3'd1; idx <= '0;
    end else if (rsp_valid) begin
      active <= 1'b1;
      idx    <= '0;
      show_q <= rsp_show;
      code_q <= rsp_code;
      bcd_q  <= to_bcd(rsp_num);
      ndig_q <= dec_len(to_bcd(rsp_num));
    end else if (active && tx_ready) begin
      if (idx == last_idx) active <= 1'b0;
      else idx <= idx + 1'b1;
    end
  end

  // R11: a stalled byte stays put until the transmitter takes it
  p_tx_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R11: a decoded line is always followed by a valid reply byte
  p_reply_starts_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> tx_valid);

  // R10: a new reply never arrives while one is still streaming
  p_no_overlap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !active);

endmodule

// File: rtl/serial_cmd_decoder.sv
module serial_cmd_decoder
  import cmd_dec_pkg::*;
#(
  parameter int               MAX_LEN   = 8,
  parameter int               HOUR_W    = 5,
  parameter int               MIN_W     = 6,
  parameter int               MODE_W    = 3,
  parameter logic [ARG_W-1:0] PPM_RESET = 16'd26400
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic [HOUR_W-1:0] cur_hours,
  input  logic [MIN_W-1:0]  cur_minutes,
  input  logic [MODE_W-1:0] mode_code,
  output logic [ARG_W-1:0]  ppm_value,
  output logic              echo_en,
  output logic              auto_send_en,
  output logic              charset_alt,
  output logic              run_en,
  output logic              time_load,
  output logic [HOUR_W-1:0] load_hours,
  output logic [MIN_W-1:0]  load_minutes
);

  line_t            line_w;
  logic             line_done_w, busy_w, reply_done_w, rsp_valid_w, rsp_show_w;
  rsp_code_e        rsp_code_w;
  logic [ARG_W-1:0] rsp_num_w;
  logic [3:0]       flags_w;

  cmd_line_asm #(.MAX_LEN(MAX_LEN)) u_asm (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .reply_done(reply_done_w), .line_o(line_w), .line_done(line_done_w),
    .busy(busy_w)
  );

  cmd_exec #(.HOUR_W(HOUR_W), .MIN_W(MIN_W), .MODE_W(MODE_W),
             .PPM_RESET(PPM_RESET), .FLAG_RESET(4'b1000)) u_exec (
    .clk(clk), .rst_n(rst_n), .line_i(line_w), .line_done(line_done_w),
    .cur_hours(cur_hours), .cur_minutes(cur_minutes), .mode_code(mode_code),
    .ppm_value(ppm_value), .flags(flags_w), .time_load(time_load),
    .load_hours(load_hours), .load_minutes(load_minutes),
    .rsp_valid(rsp_valid_w), .rsp_code(rsp_code_w), .rsp_show(rsp_show_w),
    .rsp_num(rsp_num_w)
  );

  cmd_reply_tx u_tx (
    .clk(clk), .rst_n(rst_n), .rsp_valid(rsp_valid_w), .rsp_code(rsp_code_w),
    .rsp_show(rsp_show_w), .rsp_num(rsp_num_w), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .reply_done(reply_done_w)
  );

  assign echo_en      = flags_w[0];
  assign auto_send_en = flags_w[1];
  assign charset_alt  = flags_w[2];
  assign run_en       = flags_w[3];

  // R10: the line stage stays blocked for the whole of a reply
  p_busy_covers_reply_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> busy_w);

endmodule

// File: tb/serial_cmd_decoder_tb.sv
module serial_cmd_decoder_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic        tx_ready = 1'b1;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic [4:0]  cur_hours = 5'd13;
  logic [5:0]  cur_minutes = 6'd7;
  logic [2:0]  mode_code = 3'd5;
  logic [15:0] ppm_value;
  logic        echo_en, auto_send_en, charset_alt, run_en;
  logic        time_load;
  logic [4:0]  load_hours;
  logic [5:0]  load_minutes;

  always #4 clk = ~clk;  // 125 MHz

  serial_cmd_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .cur_hours(cur_hours), .cur_minutes(cur_minutes), .mode_code(mode_code),
    .ppm_value(ppm_value), .echo_en(echo_en), .auto_send_en(auto_send_en),
    .charset_alt(charset_alt), .run_en(run_en), .time_load(time_load),
    .load_hours(load_hours), .load_minutes(load_minutes)
  );

  typedef struct { logic [7:0] b; string tag; } exp_t;
  exp_t exp_q[$];

  int n_checks = 0, n_fail = 0;
  int cyc = 0, lf_cyc = 0;
  bit meas_on = 1'b0, prev_valid = 1'b0, finished = 1'b0;
  int load_cnt = 0, got_h = 0, got_m = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid && !prev_valid && meas_on) begin
        chk("R11 latency", cyc - lf_cyc, 2);
        meas_on = 1'b0;
      end
      prev_valid = tx_valid;
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) chk("unexpected reply byte", int'(tx_data), -1);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(e.tag, int'(tx_data), int'(e.b));
        end
      end
      if (time_load) begin
        load_cnt++;
        got_h = int'(load_hours);
        got_m = int'(load_minutes);
      end
    end
  end

  task automatic push_reply(input string s, input string tag);
    for (int i = 0; i < s.len(); i++) begin
      exp_t e;
      e.b = s[i];
      e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  task automatic send(input string s, input bit meas);
    for (int i = 0; i < s.len(); i++) begin
      @(posedge clk); #1;
      rx_valid = 1'b1;
      rx_data  = s[i];
      if (meas && i == s.len() - 1) begin
        lf_cyc  = cyc + 1;
        meas_on = 1'b1;
      end
    end
    @(posedge clk); #1;
    rx_valid = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      if (exp_q.size() == 0 && !tx_valid) break;
    end
    repeat (3) @(negedge clk);
    chk("reply drained", exp_q.size(), 0);
  endtask

  task automatic cmd(input string line, input string reply, input string tag);
    push_reply(reply, tag);
    send(line, 1'b0);
    drain();
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ppm reset", ppm_value, 26400);
    chk("R1 flags reset", {echo_en, auto_send_en, charset_alt, run_en}, 4'b0001);
    chk("R1 tx idle", tx_valid, 0);

    push_reply("=OK\n", "R2 P26412 reply");
    send("P26412\n", 1'b1);
    drain();
    chk("R2 ppm written", ppm_value, 26412);
    cmd("P\n", "26412=OK\n", "R4 bare P");
    cmd("P0\n", "=ERR:INV\n", "R3 zero arg");
    cmd("P65536\n", "=ERR:INV\n", "R3 overflow arg");
    chk("R3 ppm kept", ppm_value, 26412);
    cmd("P65535\n", "=OK\n", "R2 max arg");
    chk("R2 ppm max", ppm_value, 65535);
    cmd("P7\n", "=OK\n", "R2 small arg");
    cmd("P\n", "7=OK\n", "R4 single digit");

    cmd("X\n", "=ERR:UC\n", "R7 unknown letter");
    cmd("\n", "=ERR:UC\n", "R7 empty line");
    cmd("p5\n", "=ERR:UC\n", "R7 lowercase");

    cmd("P123456789\n", "=ERR:INV\n", "R8 long line");
    chk("R8 ppm kept", ppm_value, 7);
    cmd("E0000001\n", "=OK\n", "R8 eight chars");
    chk("R8 echo set", echo_en, 1);
    cmd("P12\r\n", "=OK\n", "R8 CR ignored");
    chk("R8 ppm after CR", ppm_value, 12);
    cmd("P1x\n", "=ERR:INV\n", "R9 bad char");
    chk("R9 ppm kept", ppm_value, 12);

    cmd("A1\n", "=OK\n", "R5 A write");
    chk("R5 auto set", auto_send_en, 1);
    cmd("A\n", "1=OK\n", "R5 A read");
    cmd("C2\n", "=ERR:INV\n", "R5 C range");
    chk("R5 charset kept", charset_alt, 0);
    cmd("R0\n", "=OK\n", "R5 R write");
    chk("R5 run cleared", run_en, 0);
    cmd("R\n", "0=OK\n", "R5 R read");

    cmd("M\n", "5=OK\n", "R4 M read");
    cmd("M3\n", "=ERR:INV\n", "R4 M with arg");

    cmd("T\n", "1307=OK\n", "R6 T read");
    cmd("T2359\n", "=OK\n", "R6 T write");
    chk("R6 load count", load_cnt, 1);
    chk("R6 load hours", got_h, 23);
    chk("R6 load minutes", got_m, 59);
    cmd("T2460\n", "=ERR:INV\n", "R6 bad hour");
    cmd("T1260\n", "=ERR:INV\n", "R6 bad minute");
    chk("R6 no load on error", load_cnt, 1);
    cmd("T5\n", "=OK\n", "R6 short time");
    chk("R6 short hours", got_h, 0);
    chk("R6 short minutes", got_m, 5);

    // R10 and R11: stall the transmitter and send a second line meanwhile
    @(posedge clk); #1 tx_ready = 1'b0;
    push_reply("=OK\n", "R10 first reply");
    send("P77\n", 1'b0);
    send("P5\n", 1'b0);
    @(negedge clk);
    chk("R11 stalled valid", tx_valid, 1);
    chk("R11 stalled data", int'(tx_data), 8'h3D);
    repeat (3) @(negedge clk);
    chk("R11 still held", int'(tx_data), 8'h3D);
    @(posedge clk); #1 tx_ready = 1'b1;
    drain();
    chk("R10 ppm from first line", ppm_value, 77);
    cmd("P\n", "77=OK\n", "R10 ignored line");

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule